// File: doc/BRIEF.md
# Multi-Rail Supply Supervisor Reset Controller

This block is the digital control core of a supervisor that watches four supply rails. Each rail has a below-window flag and an above-window flag, both already turned into logic levels by comparators outside this block. For each flag the block drives a dedicated active-low fault output, and from all flags together it drives one active-low system reset. A push-button style manual reset, a margin-test override and a lockout input from a supply-level detector also feed into the outputs.

All inputs are asynchronous to the block clock and pass through two-flop synchronizers first. The reset output falls as soon as any fault or an accepted manual reset appears. It rises again only after every condition has stayed clear for one whole timeout. The timeout length comes from a configuration input, and a zero value or the fixed-mode select falls back to a built-in default. While margin testing is active, every output is released high and monitoring goes on underneath. When the margin input returns high, a short exit delay passes before the outputs follow the monitored state. The lockout input overrides everything and drives every output low.

Top module: `supply_supervisor_core`

## Requirements
- R1: Two clock edges after `uv_flag_i[k]` changes, `uv_fault_n_o[k]` equals its inverse (flag 1 = rail below window, output 0 = fault), as long as neither the margin override nor the lockout is active. A change is not visible after one edge.
- R2: `ov_fault_n_o[k]` follows the inverse of `ov_flag_i[k]` (flag 1 = rail above window) with the same two-edge latency. Every channel is independent of the others.
- R3: With no override active, `sys_rst_n_o` is 0 whenever any synchronized fault flag is set or the filtered manual reset is active.
- R4: `sys_rst_n_o` rises only after all faults, the manual reset and the lockout have been clear for exactly T consecutive cycles, counted from the first cycle the clear state is seen after synchronization. Any new condition during the count restarts it from zero.
- R5: T equals `tmo_cycles_i` when that value is non-zero and `fixed_tmo_i` is 0. Otherwise T equals the parameter `DEFAULT_TIMEOUT`.
- R6: A low pulse on `mrst_n_i` shorter than `MR_FILT_CYCLES` cycles has no effect on `sys_rst_n_o`. A low level held for `MR_FILT_CYCLES` cycles or more is accepted, and its release is filtered the same way.
- R7: While the synchronized `margin_n_i` is 0, all fault outputs and `sys_rst_n_o` read 1. The faults and the timeout counter keep being evaluated during this time, so a timeout that completes under margin shows as a released reset afterwards.
- R8: After `margin_n_i` returns to 1, the outputs stay released for `MARGIN_EXIT_CYCLES` more cycles beyond the synchronizer latency, and then they show the monitored state.
- R9: While the synchronized `lockout_i` is 1, every fault output and `sys_rst_n_o` read 0, even if margin is also active. Lockout also restarts the timeout.
- R10: Out of block reset, the lockout synchronizer starts asserted and the timeout counter starts cleared. All outputs read 0 during reset, and `sys_rst_n_o` stays 0 for a full default timeout even when no fault is present.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low block reset |
| uv_flag_i | input | NUM_RAILS | Per-rail below-window flag, 1 = fault |
| ov_flag_i | input | NUM_RAILS | Per-rail above-window flag, 1 = fault |
| mrst_n_i | input | 1 | Active-low manual reset request |
| margin_n_i | input | 1 | Active-low margin-test override |
| lockout_i | input | 1 | Supply lockout, 1 forces every output low |
| fixed_tmo_i | input | 1 | 1 selects the built-in default timeout |
| tmo_cycles_i | input | CNT_W | Programmed timeout in cycles, 0 selects the default |
| uv_fault_n_o | output | NUM_RAILS | Active-low below-window fault per rail |
| ov_fault_n_o | output | NUM_RAILS | Active-low above-window fault per rail |
| sys_rst_n_o | output | 1 | Active-low system reset |

## Verification
The hardest state to reach is a timeout that finishes while margin hides every output. The bench raises a fault under margin, clears it, and waits long enough for the counter to finish before releasing margin. It then samples after the exit delay but before a fresh timeout could have run, so a released reset at that point shows the counter kept running. The restart rule uses the same timing approach: a second fault of two cycles is injected midway through a count, and the bench samples at a point where the original count would already have released the reset. The priority of lockout over margin is exercised by asserting both together.

// File: rtl/supv_pkg.sv
package supv_pkg;
  typedef enum logic [1:0] {
    DRV_MONITOR = 2'd0,
    DRV_RELEASE = 2'd1,
    DRV_FORCE   = 2'd2
  } drive_mode_e;
endpackage

// File: rtl/supv_sync.sv
module supv_sync #(
  parameter int W = 1,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= RST_VAL;
      q      <= RST_VAL;
    end else begin
      meta_q <= d;
      q      <= meta_q;
    end
  end
endmodule

// File: rtl/supv_mr_filter.sv
module supv_mr_filter #(
  parameter int FILT_CYCLES = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic mr_n_s,
  output logic mr_act
);
  localparam int CW = $clog2(FILT_CYCLES + 1);
  localparam logic [CW-1:0] LAST = CW'(FILT_CYCLES - 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          act_d;
  logic          differ;

  assign differ = (~mr_n_s) != mr_act;

  always_comb begin
    cnt_d = '0;
    act_d = mr_act;
    if (differ) begin
      if (cnt_q == LAST) begin
        act_d = ~mr_act;
      end else begin
        cnt_d = cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      mr_act <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      mr_act <= act_d;
    end
  end
endmodule

// File: rtl/supv_timeout.sv
module supv_timeout #(
  parameter int CNT_W           = 24,
  parameter int DEFAULT_TIMEOUT = 10_000_000
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             restart,
  input  logic             fixed_sel,
  input  logic [CNT_W-1:0] prog_len,
  output logic             hold
);
  localparam logic [CNT_W-1:0] DEF_LEN = CNT_W'(DEFAULT_TIMEOUT);

  logic [CNT_W-1:0] cnt_q, cnt_d, limit;
  logic             hold_d, cnt_en;

  assign limit  = (fixed_sel || (prog_len == '0)) ? DEF_LEN : prog_len;
  assign cnt_en = restart | hold;

  always_comb begin
    cnt_d  = cnt_q;
    hold_d = hold;
    if (restart) begin
      cnt_d  = '0;
      hold_d = 1'b1;
    end else if (hold) begin
      if (({1'b0, cnt_q} + 1'b1) >= {1'b0, limit}) begin
        cnt_d  = '0;
        hold_d = 1'b0;
      end else begin
        cnt_d = cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      hold  <= 1'b1;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
      hold  <= hold_d;
    end
  end
endmodule

// File: rtl/supply_supervisor_core.sv
module supply_supervisor_core
  import supv_pkg::*;
#(
  parameter int NUM_RAILS          = 4,
  parameter int CNT_W              = 24,
  parameter int DEFAULT_TIMEOUT    = 10_000_000,
  parameter int MR_FILT_CYCLES     = 8,
  parameter int MARGIN_EXIT_CYCLES = 1000
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_RAILS-1:0] uv_flag_i,
  input  logic [NUM_RAILS-1:0] ov_flag_i,
  input  logic                 mrst_n_i,
  input  logic                 margin_n_i,
  input  logic                 lockout_i,
  input  logic                 fixed_tmo_i,
  input  logic [CNT_W-1:0]     tmo_cycles_i,
  output logic [NUM_RAILS-1:0] uv_fault_n_o,
  output logic [NUM_RAILS-1:0] ov_fault_n_o,
  output logic                 sys_rst_n_o
);
  localparam int SW = 2 * NUM_RAILS + 3;
  localparam int MW = $clog2(MARGIN_EXIT_CYCLES + 1);
  localparam logic [MW-1:0] EXIT_LEN = MW'(MARGIN_EXIT_CYCLES);
  // lockout=1, margin_n=1, mr_n=1, flags=0 while in reset
  localparam logic [SW-1:0] SYNC_RST = {3'b111, {(2 * NUM_RAILS){1'b0}}};

  logic [SW-1:0]        sync_q;
  logic [NUM_RAILS-1:0] uv_s, ov_s;
  logic                 mr_n_s, margin_n_s, lock_s;
  logic                 mr_act, hold, fault_any, restart, mask;
  logic [MW-1:0]        exit_q, exit_d;
  logic                 exit_en;
  drive_mode_e          mode;

  supv_sync #(.W(SW), .RST_VAL(SYNC_RST)) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .d    ({lockout_i, margin_n_i, mrst_n_i, ov_flag_i, uv_flag_i}),
    .q    (sync_q)
  );

  assign uv_s       = sync_q[NUM_RAILS-1:0];
  assign ov_s       = sync_q[2*NUM_RAILS-1:NUM_RAILS];
  assign mr_n_s     = sync_q[2*NUM_RAILS];
  assign margin_n_s = sync_q[2*NUM_RAILS+1];
  assign lock_s     = sync_q[2*NUM_RAILS+2];

  supv_mr_filter #(.FILT_CYCLES(MR_FILT_CYCLES)) u_mr (
    .clk   (clk),
    .rst_n (rst_n),
    .mr_n_s(mr_n_s),
    .mr_act(mr_act)
  );

  assign fault_any = (|uv_s) | (|ov_s) | mr_act;
  assign restart   = fault_any | lock_s;

  supv_timeout #(.CNT_W(CNT_W), .DEFAULT_TIMEOUT(DEFAULT_TIMEOUT)) u_tmo (
    .clk      (clk),
    .rst_n    (rst_n),
    .restart  (restart),
    .fixed_sel(fixed_tmo_i),
    .prog_len (tmo_cycles_i),
    .hold     (hold)
  );

  // margin exit window: reload while margin held, count down after release
  assign exit_en = !margin_n_s || (exit_q != '0);

  always_comb begin
    if (!margin_n_s) exit_d = EXIT_LEN;
    else             exit_d = exit_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       exit_q <= '0;
    else if (exit_en) exit_q <= exit_d;
  end

  assign mask = exit_en;

  always_comb begin
    if (lock_s)    mode = DRV_FORCE;
    else if (mask) mode = DRV_RELEASE;
    else           mode = DRV_MONITOR;
  end

  always_comb begin
    unique case (mode)
      DRV_FORCE: begin
        uv_fault_n_o = '0;
        ov_fault_n_o = '0;
        sys_rst_n_o  = 1'b0;
      end
      DRV_RELEASE: begin
        uv_fault_n_o = '1;
        ov_fault_n_o = '1;
        sys_rst_n_o  = 1'b1;
      end
      default: begin
        uv_fault_n_o = ~uv_s;
        ov_fault_n_o = ~ov_s;
        sys_rst_n_o  = ~(hold | fault_any);
      end
    endcase
  end
endmodule

// File: rtl/supv_checker.sv
module supv_checker #(
  parameter int N = 4
) (
  input logic         clk,
  input logic         rst_n,
  input logic [N-1:0] uv_flag_i,
  input logic         lockout_i,
  input logic         mr_n_s,
  input logic         mr_act,
  input logic         lock_s,
  input logic         mask,
  input logic         fault_any,
  input logic [N-1:0] uv_fault_n_o,
  input logic [N-1:0] ov_fault_n_o,
  input logic         sys_rst_n_o
);
  logic [1:0] age_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              age_q <= 2'd0;
    else if (age_q != 2'd3)  age_q <= age_q + 2'd1;
  end

  assert_uv_follows_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (age_q == 2'd3 && !mask && !lock_s) |-> (uv_fault_n_o == ~$past(uv_flag_i, 2)));

  assert_fault_pulls_reset_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!mask && !lock_s && fault_any) |-> !sys_rst_n_o);

  assert_release_after_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(sys_rst_n_o) && !mask && !$past(mask) && !lock_s && !$past(lock_s))
      |-> !$past(fault_any));

  assert_mr_accept_filtered_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mr_act) |-> (!$past(mr_n_s) && !$past(mr_n_s, 2)));

  assert_mr_release_filtered_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(mr_act) |-> ($past(mr_n_s) && $past(mr_n_s, 2)));

  assert_margin_releases_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (mask && !lock_s) |-> (uv_fault_n_o == '1 && ov_fault_n_o == '1 && sys_rst_n_o));

  assert_lock_forces_low_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (age_q == 2'd3 && $past(lockout_i, 2))
      |-> (uv_fault_n_o == '0 && ov_fault_n_o == '0 && !sys_rst_n_o));
endmodule

bind supply_supervisor_core supv_checker #(.N(NUM_RAILS)) chk_i (
  .clk         (clk),
  .rst_n       (rst_n),
  .uv_flag_i   (uv_flag_i),
  .lockout_i   (lockout_i),
  .mr_n_s      (mr_n_s),
  .mr_act      (mr_act),
  .lock_s      (lock_s),
  .mask        (mask),
  .fault_any   (fault_any),
  .uv_fault_n_o(uv_fault_n_o),
  .ov_fault_n_o(ov_fault_n_o),
  .sys_rst_n_o (sys_rst_n_o)
);

// File: tb/supply_supervisor_core_tb_top.sv
`timescale 1ns/1ps
module supply_supervisor_core_tb_top;
  localparam int N    = 4;
  localparam int CW   = 16;
  localparam int DEF  = 40;
  localparam int FILT = 5;
  localparam int EXIT = 10;

  logic          clk;
  logic          rst_n;
  logic [N-1:0]  uv_flag, ov_flag;
  logic          mrst_n, margin_n, lockout, fixed_tmo;
  logic [CW-1:0] tmo_cycles;
  logic [N-1:0]  uv_fault_n, ov_fault_n;
  logic          sys_rst_n;

  int checks   = 0;
  int failures = 0;
  int cycles   = 0;
  bit finished = 0;

  logic [8:0] exp_q[$];
  string      tag_q[$];

  supply_supervisor_core #(
    .NUM_RAILS(N), .CNT_W(CW), .DEFAULT_TIMEOUT(DEF),
    .MR_FILT_CYCLES(FILT), .MARGIN_EXIT_CYCLES(EXIT)
  ) dut_i (
    .clk(clk), .rst_n(rst_n), .uv_flag_i(uv_flag), .ov_flag_i(ov_flag),
    .mrst_n_i(mrst_n), .margin_n_i(margin_n), .lockout_i(lockout),
    .fixed_tmo_i(fixed_tmo), .tmo_cycles_i(tmo_cycles),
    .uv_fault_n_o(uv_fault_n), .ov_fault_n_o(ov_fault_n), .sys_rst_n_o(sys_rst_n)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic expect_out(input logic [N-1:0] uvn, input logic [N-1:0] ovn,
                            input logic rst, input string tag);
    exp_q.push_back({uvn, ovn, rst});
    tag_q.push_back(tag);
  endtask

  // monitor: compares queued expectations away from the clock edge
  initial begin
    forever begin
      @(negedge clk);
      #3;
      while (exp_q.size() > 0) begin
        logic [8:0] e;
        logic [8:0] a;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        a = {uv_fault_n, ov_fault_n, sys_rst_n};
        checks++;
        if (a !== e) begin
          failures++;
          $display("FAIL %s: actual uv_n=%b ov_n=%b rst_n=%b expected uv_n=%b ov_n=%b rst_n=%b",
                   t, a[8:5], a[4:1], a[0], e[8:5], e[4:1], e[0]);
        end
      end
    end
  end

  // watchdog
  initial begin
    while (!finished) begin
      @(posedge clk);
      cycles++;
      if (cycles > 100000) begin
        failures++;
        $display("FAIL watchdog: actual cycles=%0d expected below 100000", cycles);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
      end
    end
  end

  initial begin
    rst_n = 1'b0; uv_flag = '0; ov_flag = '0; mrst_n = 1'b1; margin_n = 1'b1;
    lockout = 1'b0; fixed_tmo = 1'b0; tmo_cycles = '0;
    cyc(3);
    expect_out(4'b0000, 4'b0000, 1'b0, "R10 outputs during reset");
    cyc(1);
    rst_n = 1'b1;
    // R10: power-on timeout with default (tmo=0), release after 42 edges
    cyc(40); expect_out(4'b1111, 4'b1111, 1'b0, "R10 reset held before default timeout");
    cyc(4);  expect_out(4'b1111, 4'b1111, 1'b1, "R10 reset released after default timeout");

    // R1 / R2 latency on ov[1]
    tmo_cycles = 16'd20;
    ov_flag = 4'b0010;
    cyc(1); expect_out(4'b1111, 4'b1111, 1'b1, "R2 no change after one edge");
    cyc(1); expect_out(4'b1111, 4'b1101, 1'b0, "R2 ov fault after two edges");
    ov_flag = 4'b0000;
    cyc(30);

    // R1 / R2 channel patterns
    uv_flag = 4'b1000; ov_flag = 4'b0001;
    cyc(4); expect_out(4'b0111, 4'b1110, 1'b0, "R1 R2 R3 pattern A");
    uv_flag = 4'b0101; ov_flag = 4'b1010;
    cyc(4); expect_out(4'b1010, 4'b0101, 1'b0, "R1 R2 R3 pattern B");

    // R4 / R5 programmed timeout 20: release after 22 edges from clear
    uv_flag = 4'b0000; ov_flag = 4'b0000;
    cyc(20); expect_out(4'b1111, 4'b1111, 1'b0, "R4 held during programmed timeout");
    cyc(4);  expect_out(4'b1111, 4'b1111, 1'b1, "R5 programmed timeout released");

    // R5 fixed mode overrides programmed value
    fixed_tmo = 1'b1;
    uv_flag = 4'b0010; cyc(4); uv_flag = 4'b0000;
    cyc(40); expect_out(4'b1111, 4'b1111, 1'b0, "R5 fixed mode uses default");
    cyc(4);  expect_out(4'b1111, 4'b1111, 1'b1, "R5 fixed mode release");
    fixed_tmo = 1'b0;

    // R5 zero programmed value selects default
    tmo_cycles = '0;
    ov_flag = 4'b1000; cyc(4); ov_flag = 4'b0000;
    cyc(40); expect_out(4'b1111, 4'b1111, 1'b0, "R5 zero selects default");
    cyc(4);  expect_out(4'b1111, 4'b1111, 1'b1, "R5 zero default release");
    tmo_cycles = 16'd20;

    // R4 restart: fault midway through count
    uv_flag = 4'b0001; cyc(4); uv_flag = 4'b0000;
    cyc(10);
    ov_flag = 4'b0100; cyc(2); ov_flag = 4'b0000;
    cyc(18); expect_out(4'b1111, 4'b1111, 1'b0, "R4 count restarted by new fault");
    cyc(6);  expect_out(4'b1111, 4'b1111, 1'b1, "R4 release after restarted count");

    // R6 short manual reset glitch rejected
    mrst_n = 1'b0; cyc(2); mrst_n = 1'b1;
    cyc(3);  expect_out(4'b1111, 4'b1111, 1'b1, "R6 short pulse ignored early");
    cyc(10); expect_out(4'b1111, 4'b1111, 1'b1, "R6 short pulse ignored late");

    // R6 / R3 long manual reset accepted; release filtered then full timeout
    mrst_n = 1'b0;
    cyc(10); expect_out(4'b1111, 4'b1111, 1'b0, "R6 R3 long manual reset accepted");
    cyc(5);
    mrst_n = 1'b1;
    cyc(25); expect_out(4'b1111, 4'b1111, 1'b0, "R6 filtered release plus timeout");
    cyc(5);  expect_out(4'b1111, 4'b1111, 1'b1, "R4 release after manual reset");

    // R7 / R8 margin with live fault
    margin_n = 1'b0; uv_flag = 4'b0001;
    cyc(4);  expect_out(4'b1111, 4'b1111, 1'b1, "R7 margin releases all outputs");
    cyc(10);
    margin_n = 1'b1;
    cyc(6);  expect_out(4'b1111, 4'b1111, 1'b1, "R8 outputs still released in exit window");
    cyc(10); expect_out(4'b1110, 4'b1111, 1'b0, "R8 monitored state after exit window");

    // R7 timeout completes under margin
    margin_n = 1'b0;
    cyc(4); uv_flag = 4'b0000;
    cyc(30);
    margin_n = 1'b1;
    cyc(16); expect_out(4'b1111, 4'b1111, 1'b1, "R7 timer ran during margin");

    // R9 lockout wins over margin
    lockout = 1'b1; margin_n = 1'b0;
    cyc(4); expect_out(4'b0000, 4'b0000, 1'b0, "R9 lockout over margin");
    margin_n = 1'b1;
    cyc(16); expect_out(4'b0000, 4'b0000, 1'b0, "R9 lockout alone");
    lockout = 1'b0;
    cyc(4);  expect_out(4'b1111, 4'b1111, 1'b0, "R9 lockout restarts timeout");
    cyc(26); expect_out(4'b1111, 4'b1111, 1'b1, "R9 release after lockout timeout");

    cyc(2);
    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule